// File: doc/BRIEF.md
# LCD Panel Timing Generator

This block produces the raster timing for a parallel RGB panel. A horizontal counter and a vertical counter step on a pixel strobe, one pixel per strobe. Each axis passes through four regions in order: active video, front porch, sync pulse, back porch. The pins come out of comparisons between the counters and the programmed sizes: horizontal sync, vertical sync, data enable and composite blank. Control bits set the polarity of each pin.

Software programs the sizes, porches and panel controls through a simple write port. The block sends a one-clock start-of-frame pulse to a pixel fetch engine whenever vertical sync becomes asserted. It also keeps a sticky frame-done status bit and drives it out as an interrupt line. Pixel data, memory fetch and pixel clock generation belong to other blocks.

Top module: `lcdt_timing_gen`

## Requirements
- R1: Write addresses: size register at 0, total register at 1, horizontal porch register at 2, vertical porch register at 3, control register at 4, status register at 5. The size and total registers hold the line count in bits 31:16 and the pixels per line in bits 15:0.
- R2: Each axis counts from 0 to total-1 and then wraps to 0, passing through these regions in order:
  - active video: [0, active)
  - front porch
  - sync: [active+front, total-back)
  - back porch
  Both porch registers hold the back porch in bits 31:16 and the front porch in bits 15:0. The sync width is total minus active minus both porches. The vertical counter advances when the horizontal counter wraps, so a frame lasts htotal*vtotal strobes.
- R3: A total above 2048 on either axis acts as 2048.
- R4: Control bit 2 set makes hsync active low, and control bit 3 set makes vsync active low. When a bit is clear, the pin is high during the sync region of its axis.
- R5: Data enable is high when both counters are inside their active regions. Control bit 4 inverts it. The pixel-clock-invert pin follows control bit 1.
- R6: Composite blank is asserted whenever data enable is not raw-active. It is active low by default. Control bit 5 makes it active high, and control bit 6 inverts the resulting pin.
- R7: A mode field value of 0x7 in control bits 31:28 forces the blanked state: data enable stays inactive and blank stays asserted, while both syncs keep running.
- R8: While control bit 0 (enable) is clear:
  - both counters are held at 0;
  - both syncs and data enable are at their inactive levels;
  - blank is asserted;
  - no fetch pulse and no new frame-done event occurs.
- R9: The fetch pulse is high for exactly one clock, in the clock after vsync becomes asserted. That is the falling pin edge when vsync is active low, and the rising edge otherwise.
- R10: When the last pixel of the last line is stepped, status bit 0 is set and stays set. The interrupt pin equals status bit 0.
- R11: Writing the status register with bit 0 at 0 clears the frame-done bit. Writing it with bit 0 at 1 leaves the bit unchanged. A frame end in the same clock as a clear wins.
- R12: The counters change only in clocks where the pixel strobe is high.
- R13: After reset all registers are zero: output is disabled, every pin is low, and the interrupt is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_ce | input | 1 | Pixel strobe, one pixel per high clock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 32 | Register write data |
| hsync_o | output | 1 | Horizontal sync pin |
| vsync_o | output | 1 | Vertical sync pin |
| de_o | output | 1 | Data enable pin |
| blank_o | output | 1 | Composite blank pin |
| pclk_inv_o | output | 1 | Pixel clock inversion select |
| fetch_o | output | 1 | Start-of-frame pulse to the fetch engine |
| irq_o | output | 1 | Frame-done interrupt |

## Verification
All pins are decoded without further registers from the counters and configuration registers:
- A register write is visible on the pins one clock after the write strobe.
- A strobed counter step shows on the pins one clock after its edge.
- The fetch pulse shows in the clock after vsync enters its sync region.
- A status write or frame end changes the interrupt one clock later.

The bench keeps a behavioural model that updates on each rising edge from the inputs driven half a cycle before. It compares every pin at the falling edge, so each result is checked in exactly the clock it is due. Frame lengths are measured as clock counts between consecutive fetch pulses, which tests the counter wrap points independently of the model.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

   typedef struct packed {
      logic [15:0] act;
      logic [15:0] tot;
      logic [15:0] fp;
      logic [15:0] bp;
   } lcdt_axis_cfg_t;

   localparam int ADR_SIZE   = 0;
   localparam int ADR_TOTAL  = 1;
   localparam int ADR_HPORCH = 2;
   localparam int ADR_VPORCH = 3;
   localparam int ADR_CTRL   = 4;
   localparam int ADR_STAT   = 5;

   localparam int B_EN       = 0;
   localparam int B_PCLK_INV = 1;
   localparam int B_HS_LOW   = 2;
   localparam int B_VS_LOW   = 3;
   localparam int B_DE_INV   = 4;
   localparam int B_BLK_HIGH = 5;
   localparam int B_BLK_INV  = 6;
   localparam int MODE_LSB   = 28;
   localparam logic [3:0] MODE_FORCE_BLANK = 4'h7;

endpackage

// File: rtl/lcdt_regs.sv
module lcdt_regs
   import lcdt_pkg::*;
#(
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [31:0]       wr_data,
   input  logic              frame_end,
   output lcdt_axis_cfg_t    h_cfg,
   output lcdt_axis_cfg_t    v_cfg,
   output logic [31:0]       ctrl,
   output logic              irq
);

   logic [31:0] size_r, total_r, hpor_r, vpor_r;
   logic        done_r;

   function automatic logic hit(input logic [ADDR_W-1:0] a, input int idx);
      return a == ADDR_W'(idx);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         size_r  <= '0;
         total_r <= '0;
         hpor_r  <= '0;
         vpor_r  <= '0;
         ctrl    <= '0;
      end else if (wr_en) begin
         if (hit(wr_addr, ADR_SIZE))   size_r  <= wr_data;
         if (hit(wr_addr, ADR_TOTAL))  total_r <= wr_data;
         if (hit(wr_addr, ADR_HPORCH)) hpor_r  <= wr_data;
         if (hit(wr_addr, ADR_VPORCH)) vpor_r  <= wr_data;
         if (hit(wr_addr, ADR_CTRL))   ctrl    <= wr_data;
      end
   end

   // sticky frame-done; a frame end outranks a same-cycle clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         done_r <= 1'b0;
      else if (frame_end)
         done_r <= 1'b1;
      else if (wr_en && hit(wr_addr, ADR_STAT) && !wr_data[0])
         done_r <= 1'b0;
   end

   assign irq   = done_r;
   assign h_cfg = '{act: size_r[15:0],  tot: total_r[15:0],
                    fp: hpor_r[15:0],   bp: hpor_r[31:16]};
   assign v_cfg = '{act: size_r[31:16], tot: total_r[31:16],
                    fp: vpor_r[15:0],   bp: vpor_r[31:16]};

endmodule

// File: rtl/lcdt_axis.sv
module lcdt_axis
   import lcdt_pkg::*;
#(
   parameter int MAX_TOTAL = 2048,
   parameter int CNT_W     = $clog2(MAX_TOTAL)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             step,
   input  lcdt_axis_cfg_t   cfg,
   output logic [CNT_W-1:0] cnt,
   output logic             in_act,
   output logic             in_sync,
   output logic             last
);

   localparam int EXT_W = 18;

   logic [EXT_W-1:0] ext, tot_raw, tot_eff, act_e, fp_e, bp_e;

   assign ext     = EXT_W'(cnt);
   assign act_e   = EXT_W'(cfg.act);
   assign fp_e    = EXT_W'(cfg.fp);
   assign bp_e    = EXT_W'(cfg.bp);
   assign tot_raw = EXT_W'(cfg.tot);
   assign tot_eff = (tot_raw > EXT_W'(MAX_TOTAL)) ? EXT_W'(MAX_TOTAL) : tot_raw;

   assign in_act  = ext < act_e;
   assign in_sync = (ext >= act_e + fp_e) && (ext + bp_e < tot_eff);
   assign last    = (ext + EXT_W'(1)) >= tot_eff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!en)
         cnt <= '0;
      else if (step)
         cnt <= last ? '0 : cnt + CNT_W'(1);
   end

endmodule

// File: rtl/lcdt_panel_out.sv
module lcdt_panel_out
   import lcdt_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic [31:0] ctrl,
   input  logic        h_act,
   input  logic        v_act,
   input  logic        h_sync,
   input  logic        v_sync,
   output logic        hsync_o,
   output logic        vsync_o,
   output logic        de_o,
   output logic        blank_o,
   output logic        pclk_inv_o,
   output logic        fetch_o,
   output logic        de_raw,
   output logic        force_blank
);

   logic en, hs_a, vs_a, vs_q, blank_raw;
   logic ctrl_unused;

   assign ctrl_unused = ^ctrl[MODE_LSB-1:B_BLK_INV+1];

   assign en          = ctrl[B_EN];
   assign force_blank = ctrl[31:MODE_LSB] == MODE_FORCE_BLANK;
   assign hs_a        = en & h_sync;
   assign vs_a        = en & v_sync;
   assign de_raw      = en & ~force_blank & h_act & v_act;
   assign blank_raw   = ~de_raw;

   assign hsync_o    = hs_a ^ ctrl[B_HS_LOW];
   assign vsync_o    = vs_a ^ ctrl[B_VS_LOW];
   assign de_o       = de_raw ^ ctrl[B_DE_INV];
   assign blank_o    = blank_raw ^ ~ctrl[B_BLK_HIGH] ^ ctrl[B_BLK_INV];
   assign pclk_inv_o = ctrl[B_PCLK_INV];

   // assertion edge of vsync, independent of pin polarity
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vs_q <= 1'b0;
      else        vs_q <= vs_a;
   end
   assign fetch_o = vs_a & ~vs_q;

endmodule

// File: rtl/lcdt_timing_gen.sv
module lcdt_timing_gen
   import lcdt_pkg::*;
#(
   parameter int MAX_TOTAL = 2048,
   parameter int ADDR_W    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pix_ce,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [31:0]       wr_data,
   output logic              hsync_o,
   output logic              vsync_o,
   output logic              de_o,
   output logic              blank_o,
   output logic              pclk_inv_o,
   output logic              fetch_o,
   output logic              irq_o
);

   localparam int CNT_W  = $clog2(MAX_TOTAL);
   localparam int N_AXIS = 2;

   if (MAX_TOTAL < 2 || MAX_TOTAL > 65535) begin : g_bad_total
      $error("MAX_TOTAL out of range");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("ADDR_W too small for register map");
   end

   lcdt_axis_cfg_t    cfg_w  [N_AXIS];
   logic [CNT_W-1:0]  cnt_w  [N_AXIS];
   logic [N_AXIS-1:0] step_w, act_w, sync_w, last_w;
   logic [31:0]       ctrl;
   logic              en, frame_end, de_raw, force_blank;
   logic [CNT_W-1:0]  h_cnt, v_cnt;

   assign en        = ctrl[B_EN];
   assign frame_end = en & pix_ce & (&last_w);
   assign h_cnt     = cnt_w[0];
   assign v_cnt     = cnt_w[1];

   lcdt_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .frame_end (frame_end),
      .h_cfg     (cfg_w[0]),
      .v_cfg     (cfg_w[1]),
      .ctrl      (ctrl),
      .irq       (irq_o)
   );

   for (genvar i = 0; i < N_AXIS; i++) begin : g_axis
      if (i == 0) begin : g_step_h
         assign step_w[i] = pix_ce;
      end else begin : g_step_v
         assign step_w[i] = pix_ce & last_w[i-1];
      end
      lcdt_axis #(.MAX_TOTAL(MAX_TOTAL), .CNT_W(CNT_W)) u_axis (
         .clk     (clk),
         .rst_n   (rst_n),
         .en      (en),
         .step    (step_w[i]),
         .cfg     (cfg_w[i]),
         .cnt     (cnt_w[i]),
         .in_act  (act_w[i]),
         .in_sync (sync_w[i]),
         .last    (last_w[i])
      );
   end

   lcdt_panel_out u_out (
      .clk         (clk),
      .rst_n       (rst_n),
      .ctrl        (ctrl),
      .h_act       (act_w[0]),
      .v_act       (act_w[1]),
      .h_sync      (sync_w[0]),
      .v_sync      (sync_w[1]),
      .hsync_o     (hsync_o),
      .vsync_o     (vsync_o),
      .de_o        (de_o),
      .blank_o     (blank_o),
      .pclk_inv_o  (pclk_inv_o),
      .fetch_o     (fetch_o),
      .de_raw      (de_raw),
      .force_blank (force_blank)
   );

endmodule

// File: rtl/lcdt_timing_chk.sv
module lcdt_timing_chk #(
   parameter int CNT_W = 11
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic             pix_ce,
   input logic             h_last,
   input logic [CNT_W-1:0] h_cnt,
   input logic [CNT_W-1:0] v_cnt,
   input logic             fetch_o,
   input logic             irq_o,
   input logic             frame_end,
   input logic             force_blank,
   input logic             de_raw
);

   assert_idle_counters_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (h_cnt == '0 && v_cnt == '0));

   assert_fetch_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_o |=> !fetch_o);

   assert_irq_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> $past(frame_end));

   assert_forced_blank_R7: assert property (@(posedge clk) disable iff (!rst_n)
      force_blank |-> !de_raw);

   assert_hold_no_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !pix_ce) |=> $stable(h_cnt));

   assert_step_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (en && pix_ce && !h_last) |=> (h_cnt == $past(h_cnt) + CNT_W'(1)));

endmodule

bind lcdt_timing_gen lcdt_timing_chk #(.CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .en          (en),
   .pix_ce      (pix_ce),
   .h_last      (last_w[0]),
   .h_cnt       (h_cnt),
   .v_cnt       (v_cnt),
   .fetch_o     (fetch_o),
   .irq_o       (irq_o),
   .frame_end   (frame_end),
   .force_blank (force_blank),
   .de_raw      (de_raw)
);

// File: tb/lcdt_timing_gen_bench.sv
module lcdt_timing_gen_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pix_ce = 1'b1;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic hsync_o, vsync_o, de_o, blank_o, pclk_inv_o, fetch_o, irq_o;

   int  checks = 0;
   int  errors = 0;
   bit  cmp_on = 1'b0;
   bit  alt_ce = 1'b0;

   always #4 clk = ~clk;

   lcdt_timing_gen u_lcdt_timing_gen (
      .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .hsync_o(hsync_o),
      .vsync_o(vsync_o), .de_o(de_o), .blank_o(blank_o),
      .pclk_inv_o(pclk_inv_o), .fetch_o(fetch_o), .irq_o(irq_o));

   // ---------------- behavioural reference model ----------------
   logic [31:0] m_size, m_tot, m_hp, m_vp, m_ctrl;
   int  mh, mv;
   bit  m_vsq, m_stat;
   bit  t_en, t_hl, t_vl, t_fend, t_vs;
   int  t_ht, t_vt;

   function automatic int eff(input int t);
      return (t > 2048) ? 2048 : t;
   endfunction

   function automatic bit in_sync(input int c, input int a, input int fp,
                                  input int bp, input int t);
      return (c >= a + fp) && (c + bp < eff(t));
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_size = 0; m_tot = 0; m_hp = 0; m_vp = 0; m_ctrl = 0;
         mh = 0; mv = 0; m_vsq = 0; m_stat = 0;
      end else begin
         t_en   = m_ctrl[0];
         t_ht   = eff(int'(m_tot[15:0]));
         t_vt   = eff(int'(m_tot[31:16]));
         t_hl   = (mh + 1 >= t_ht);
         t_vl   = (mv + 1 >= t_vt);
         t_vs   = t_en && in_sync(mv, int'(m_size[31:16]), int'(m_vp[15:0]),
                                  int'(m_vp[31:16]), int'(m_tot[31:16]));
         t_fend = t_en && pix_ce && t_hl && t_vl;
         m_vsq  = t_vs;
         if (!t_en) begin
            mh = 0; mv = 0;
         end else if (pix_ce) begin
            if (t_hl) begin
               mh = 0;
               mv = t_vl ? 0 : mv + 1;
            end else mh = mh + 1;
         end
         if (t_fend) m_stat = 1;
         else if (wr_en && wr_addr == 3'd5 && !wr_data[0]) m_stat = 0;
         if (wr_en) begin
            case (wr_addr)
               3'd0: m_size = wr_data;
               3'd1: m_tot  = wr_data;
               3'd2: m_hp   = wr_data;
               3'd3: m_vp   = wr_data;
               3'd4: m_ctrl = wr_data;
               default: ;
            endcase
         end
      end
   end

   task automatic check(input string tag, input string name, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, name, act, exp, $time);
      end
   endtask

   // compare every pin at the falling edge
   always @(negedge clk) begin
      if (cmp_on && rst_n) begin
         bit en, hs_a, vs_a, de_r, frc;
         en   = m_ctrl[0];
         frc  = (m_ctrl[31:28] == 4'h7);
         hs_a = en && in_sync(mh, int'(m_size[15:0]), int'(m_hp[15:0]),
                              int'(m_hp[31:16]), int'(m_tot[15:0]));
         vs_a = en && in_sync(mv, int'(m_size[31:16]), int'(m_vp[15:0]),
                              int'(m_vp[31:16]), int'(m_tot[31:16]));
         de_r = en && !frc && (mh < int'(m_size[15:0])) && (mv < int'(m_size[31:16]));
         check("R4", "hsync", int'(hsync_o), int'(hs_a ^ m_ctrl[2]));
         check("R4", "vsync", int'(vsync_o), int'(vs_a ^ m_ctrl[3]));
         check("R5", "de", int'(de_o), int'(de_r ^ m_ctrl[4]));
         check("R6", "blank", int'(blank_o), int'((!de_r) ^ (!m_ctrl[5]) ^ m_ctrl[6]));
         check("R5", "pclk_inv", int'(pclk_inv_o), int'(m_ctrl[1]));
         check("R9", "fetch", int'(fetch_o), int'(vs_a && !m_vsq));
         check("R10", "irq", int'(irq_o), int'(m_stat));
      end
   end

   always @(negedge clk) if (alt_ce) pix_ce <= ~pix_ce;

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic measure(output int per);
      int n = 0;
      while (!fetch_o && n < 20000) begin @(negedge clk); n++; end
      @(negedge clk);
      n = 1;
      while (!fetch_o && n < 20000) begin @(negedge clk); n++; end
      per = n;
   endtask

   task automatic frame_len(input string tag, input int exp);
      int p;
      measure(p);
      measure(p);
      check(tag, "frame period", p, exp);
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int cnt_a, cnt_b;
      repeat (3) @(negedge clk);
      // R13 reset state
      check("R13", "hsync", int'(hsync_o), 0);
      check("R13", "vsync", int'(vsync_o), 0);
      check("R13", "de", int'(de_o), 0);
      check("R13", "blank", int'(blank_o), 0);
      check("R13", "irq", int'(irq_o), 0);
      rst_n = 1'b1;
      cmp_on = 1'b1;
      // R1 R2: h 8 act, fp 2, bp 3, tot 16 ; v 4 act, fp 1, bp 2, tot 9
      wr(0, {16'd4, 16'd8});
      wr(1, {16'd9, 16'd16});
      wr(2, {16'd3, 16'd2});
      wr(3, {16'd2, 16'd1});
      wr(4, 32'h1);
      frame_len("R1", 144);
      frame_len("R2", 144);
      // R10 R11 status behaviour, right after a fetch pulse
      check("R10", "irq after frame", int'(irq_o), 1);
      wr(5, 32'h1);
      check("R11", "irq after write 1", int'(irq_o), 1);
      wr(5, 32'h0);
      check("R11", "irq after write 0", int'(irq_o), 0);
      // R4 active-low syncs
      wr(4, 32'hD);
      frame_len("R4", 144);
      // R12 strobe every other clock
      alt_ce = 1'b1;
      frame_len("R12", 288);
      alt_ce = 1'b0;
      @(negedge clk);
      pix_ce = 1'b1;
      // R7 forced blank mode
      wr(4, 32'h7000_0001);
      cnt_a = 0; cnt_b = 0;
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         if (de_o) cnt_a++;
         if (hsync_o) cnt_b++;
      end
      check("R7", "de high cycles", cnt_a, 0);
      check("R7", "hsync running", int'(cnt_b > 0), 1);
      // R5 R6 inversion controls
      wr(4, 32'h73);
      check("R5", "pclk_inv", int'(pclk_inv_o), 1);
      frame_len("R6", 144);
      // R3 total clamp: h total 3000, v 1 active 3 total
      wr(4, 32'h0);
      wr(0, {16'd1, 16'd8});
      wr(1, {16'd3, 16'd3000});
      wr(3, 32'h0);
      wr(4, 32'h1);
      frame_len("R3", 6144);
      // R8 disable: syncs active low, expect idle pins
      wr(4, 32'hC);
      cnt_a = 0;
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (fetch_o) cnt_a++;
      end
      check("R8", "fetch while off", cnt_a, 0);
      check("R8", "hsync idle", int'(hsync_o), 1);
      check("R8", "vsync idle", int'(vsync_o), 1);
      check("R8", "de idle", int'(de_o), 0);
      check("R8", "blank asserted", int'(blank_o), 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule